// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This unit performs 16-bit arithmetic for the register-pair instructions of a classic 8-bit processor core. Each operation takes a destination pair value, a source operand, the current flag byte and a two-bit operation code. It produces a 16-bit result and an updated flag byte. The operations are a plain add, an add that chains in the incoming carry, and a subtract that chains in the incoming carry as a borrow.

The plain add is the cheap form that address arithmetic uses. It changes only the carry, half-carry and subtract flags, and it passes sign, zero and parity/overflow through unchanged. The two carry-chained forms take part in multi-word arithmetic. For these, sign, zero and overflow are computed over the whole 16-bit result. The flag byte uses the same bit layout as the core's 8-bit arithmetic unit, so the core can store it without reordering.

Operands are captured on an input strobe. The result and flags appear in output registers one cycle later, together with a one-cycle valid pulse, and they stay there until the next strobe.

Top module: `pair_alu`

## Requirements
- R1: While reset is high, and after it falls until the first strobe, out_valid, result and flags_out are all zero.
- R2: out_valid is high in exactly the cycles that follow a cycle with in_valid high.
- R3: When in_valid is low, result and flags_out keep their values into the next cycle.
- R4: Op code 0 (plain add) gives result = (dst + src) mod 65536. It sets carry (flag bit 0) to bit 16 of the sum and clears subtract (flag bit 1).
- R5: Op code 0 copies sign (bit 7), zero (bit 6) and parity/overflow (bit 2) from flags_in to flags_out unchanged.
- R6: Op code 1 (add with carry) gives result = (dst + src + flags_in[0]) mod 65536. It sets carry to bit 16 of that sum and clears subtract.
- R7: Op code 2 (subtract with carry) gives result = (dst - src - flags_in[0]) mod 65536. It sets carry when the true difference is negative, and it sets subtract.
- R8: For op codes 1 and 2, zero (bit 6) is set exactly when the 16-bit result is zero, and sign (bit 7) equals result bit 15.
- R9: For op code 1, overflow (bit 2) is set when dst and src have equal bit 15 and the result's bit 15 differs from it. For op code 2, it is set when dst and src differ in bit 15 and the result's bit 15 differs from dst's.
- R10: Half-carry (bit 4) is the carry out of bit 11 for the adds, or the borrow out of bit 11 for the subtract. In each case the incoming carry is included.
- R11: Flag bits 5 and 3 are always zero in flags_out.
- R12: Op code 3 behaves exactly like op code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture an operation this cycle |
| op | input | 2 | 0 plain add, 1 add with carry, 2 subtract with carry, 3 as 0 |
| dst | input | 16 | Destination pair value (first operand) |
| src | input | 16 | Source operand |
| flags_in | input | 8 | Incoming flag byte |
| out_valid | output | 1 | One-cycle pulse when a new result is present |
| result | output | 16 | Registered 16-bit result |
| flags_out | output | 8 | Registered updated flag byte |

## Verification
The output registers are the only state in the block. A wrong value captured there shows at the ports one cycle after the strobe and stays visible until the next strobe. Because of this, a per-cycle reference comparison catches each fault in the cycle it appears. The risky internal choices are the operand inversion and the carry-in inversion for subtraction, and the selection between passing flags through and recomputing them. A slip in the inversion shows up as a wrong carry or half-carry on borrow cases, such as 0 minus 0 with carry in. A slip in the flag selection shows up as sign, zero or overflow tracking the result on a plain add. Directed boundary vectors force these cases, and long random runs cover the rest.

// File: rtl/pair_alu_pkg.sv
package pair_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_ADC  = 2'd1,
    OP_SBC  = 2'd2,
    OP_ADD2 = 2'd3
  } pair_op_e;

  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_X3 = 3;
  localparam int FB_H  = 4;
  localparam int FB_X5 = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

endpackage

// File: rtl/pair_alu_adder.sv
module pair_alu_adder
  import pair_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  pair_op_e           op,
  input  logic [WIDTH-1:0]   dst,
  input  logic [WIDTH-1:0]   src,
  input  logic               cin,
  output logic [WIDTH-1:0]   sum,
  output logic               carry,
  output logic               half,
  output logic               ovf
);
  localparam int MSB      = WIDTH - 1;
  localparam int HALF_BIT = WIDTH - 4;

  logic             is_sub;
  logic             chain;
  logic [WIDTH-1:0] b_eff;
  logic             c_eff;
  logic [WIDTH:0]   raw;
  logic [WIDTH-1:0] xor_vec;

  // Subtraction as dst + ~src + ~cin; the carry outputs are inverted to give borrows.
  always_comb begin
    is_sub  = (op == OP_SBC);
    chain   = (op == OP_ADC) || (op == OP_SBC);
    b_eff   = is_sub ? ~src : src;
    c_eff   = is_sub ? ~cin : (chain & cin);
    raw     = {1'b0, dst} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
    sum     = raw[MSB:0];
    xor_vec = dst ^ b_eff ^ sum;
    carry   = raw[WIDTH] ^ is_sub;
    half    = xor_vec[HALF_BIT] ^ is_sub;
    ovf     = (dst[MSB] == b_eff[MSB]) && (sum[MSB] != dst[MSB]);
  end

endmodule

// File: rtl/pair_alu_flags.sv
module pair_alu_flags
  import pair_alu_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int FLAG_W = 8
) (
  input  pair_op_e          op,
  input  logic [WIDTH-1:0]  sum,
  input  logic              carry,
  input  logic              half,
  input  logic              ovf,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_nx
);
  localparam int MSB = WIDTH - 1;

  logic chain;

  always_comb begin
    chain          = (op == OP_ADC) || (op == OP_SBC);
    flags_nx       = '0;
    flags_nx[FB_C] = carry;
    flags_nx[FB_H] = half;
    flags_nx[FB_N] = (op == OP_SBC);
    if (chain) begin
      flags_nx[FB_S]  = sum[MSB];
      flags_nx[FB_Z]  = ~|sum;
      flags_nx[FB_PV] = ovf;
    end else begin
      flags_nx[FB_S]  = flags_in[FB_S];
      flags_nx[FB_Z]  = flags_in[FB_Z];
      flags_nx[FB_PV] = flags_in[FB_PV];
    end
  end

endmodule

// File: rtl/pair_alu.sv
module pair_alu
  import pair_alu_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [WIDTH-1:0]  dst,
  input  logic [WIDTH-1:0]  src,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [WIDTH-1:0]  result,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int MSB = WIDTH - 1;

  pair_op_e          op_q;
  logic [WIDTH-1:0]  sum_w;
  logic              carry_w;
  logic              half_w;
  logic              ovf_w;
  logic [FLAG_W-1:0] flags_w;

  assign op_q = pair_op_e'(op);

  pair_alu_adder #(.WIDTH(WIDTH)) u_add (
    .op    (op_q),
    .dst   (dst),
    .src   (src),
    .cin   (flags_in[FB_C]),
    .sum   (sum_w),
    .carry (carry_w),
    .half  (half_w),
    .ovf   (ovf_w)
  );

  pair_alu_flags #(.WIDTH(WIDTH), .FLAG_W(FLAG_W)) u_flg (
    .op       (op_q),
    .sum      (sum_w),
    .carry    (carry_w),
    .half     (half_w),
    .ovf      (ovf_w),
    .flags_in (flags_in),
    .flags_nx (flags_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sum_w;
        flags_out <= flags_w;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(flags_out))); // R3
  AST_ADD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 2'd0 || op == 2'd3)) |=>
      (flags_out[FB_S] == $past(flags_in[FB_S]) && flags_out[FB_Z] == $past(flags_in[FB_Z])
       && flags_out[FB_PV] == $past(flags_in[FB_PV]))); // R5
  AST_SBC_SETS_N: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd2) |=> flags_out[FB_N]); // R7
  AST_CHAIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 2'd1 || op == 2'd2)) |=> (flags_out[FB_Z] == (result == '0))); // R8
  AST_CHAIN_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 2'd1 || op == 2'd2)) |=> (flags_out[FB_S] == result[MSB])); // R8
  AST_SPARE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!flags_out[FB_X5] && !flags_out[FB_X3])); // R11

endmodule

// File: tb/pair_alu_bench.sv
module pair_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] dst = 16'h0;
  logic [15:0] src = 16'h0;
  logic [7:0]  flags_in = 8'h0;
  logic        out_valid;
  logic [15:0] result;
  logic [7:0]  flags_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic        e_valid = 1'b0;
  logic [15:0] e_res = 16'h0;
  logic [7:0]  e_flg = 8'h0;
  string       e_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_alu u_pair_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .dst(dst), .src(src),
    .flags_in(flags_in), .out_valid(out_valid), .result(result), .flags_out(flags_out)
  );

  // Behavioural reference: integer arithmetic straight from the requirements.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      e_valid <= 1'b0; e_res <= 16'h0; e_flg <= 8'h0; e_tag <= "R1";
    end else begin
      e_valid <= in_valid;
      if (!in_valid) e_tag <= "R3";
      else begin
        int d, s, ci, full, r, hc, c, v;
        logic [7:0] f;
        d = dst; s = src; ci = flags_in[0];
        if (op == 2'd2) begin
          full = d - s - ci;
          c    = (full < 0);
          hc   = (((d % 4096) - (s % 4096) - ci) < 0);
        end else begin
          if (op != 2'd1) ci = 0;
          full = d + s + ci;
          c    = (full >= 65536);
          hc   = (((d % 4096) + (s % 4096) + ci) >= 4096);
        end
        r = (full + 65536) % 65536;
        f = 8'h0;
        f[0] = c[0];
        f[4] = hc[0];
        f[1] = (op == 2'd2);
        if (op == 2'd1 || op == 2'd2) begin
          f[7] = (r >= 32768);
          f[6] = (r == 0);
          if (op == 2'd1) v = ((d >= 32768) == (s >= 32768)) && ((r >= 32768) != (d >= 32768));
          else            v = ((d >= 32768) != (s >= 32768)) && ((r >= 32768) != (d >= 32768));
          f[2] = v[0];
          e_tag <= (op == 2'd1) ? "R6 R8 R9 R10 R11" : "R7 R8 R9 R10 R11";
        end else begin
          f[7] = flags_in[7]; f[6] = flags_in[6]; f[2] = flags_in[2];
          e_tag <= (op == 2'd3) ? "R12 R4 R5 R10 R11" : "R4 R5 R10 R11";
        end
        e_res <= r[15:0];
        e_flg <= f;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // Compare every clock, a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      chk(out_valid == e_valid, "R2", out_valid, e_valid);
      chk(result == e_res, e_tag, result, e_res);
      chk(flags_out == e_flg, e_tag, flags_out, e_flg);
    end
  end

  task automatic go(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                    input logic [7:0] f);
    @(negedge clk);
    in_valid = 1'b1; op = o; dst = a; src = b; flags_in = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op = 2'($urandom); dst = 16'($urandom);
      src = 16'($urandom); flags_in = 8'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && result == 16'h0 && flags_out == 8'h0, "R1",
        {out_valid, result, flags_out}, 0);
    rst = 1'b0;
    idle(2);
    go(2'd0, 16'hFFFF, 16'h0001, 8'hC4); // R4 carry, R5 keep, R10 half
    go(2'd0, 16'h1234, 16'h0FFF, 8'h01); // R4 carry in ignored
    go(2'd1, 16'h7FFF, 16'h0000, 8'h01); // R6 R9 overflow into sign
    go(2'd1, 16'hFFFF, 16'h0000, 8'h01); // R6 R8 zero with carry out
    go(2'd2, 16'h0000, 16'h0000, 8'h01); // R7 borrow all the way
    go(2'd2, 16'h8000, 16'h0001, 8'h00); // R9 subtract overflow
    go(2'd2, 16'h5A5A, 16'h5A5A, 8'h00); // R8 zero
    go(2'd3, 16'h8000, 16'h8000, 8'hFF); // R12
    idle(3);                             // R3 hold with noisy inputs
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      in_valid = 1'($urandom); op = 2'($urandom); flags_in = 8'($urandom);
      dst = (i % 7 == 0) ? 16'hFFFF : 16'($urandom);
      src = (i % 11 == 0) ? 16'h0000 : 16'($urandom);
    end
    @(negedge clk); in_valid = 1'b0;
    idle(3);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule